// File: doc/BRIEF.md
# Hybrid Direct/Ternary Subtrie Index Table

This block sits at the front of a longest-prefix-match engine that spreads its routing trie over several parallel lookup pipelines. For each destination address it decides which pipeline handles the lookup, in which stage of that pipeline the subtrie root is stored, and at which node address of that stage the root sits.

Each address is searched two ways in the same cycle. A direct table is indexed by the top `IDX_BITS` address bits and covers the coarse subtries. A small register-based ternary array holds the prefixes of deeper, height-split subtries. The longest matching ternary entry selects a slot in a second route table. A usable ternary result always takes priority over the direct result. The answer is registered, so it appears one cycle after the request.

A single write port loads any of the three stores: the direct table, the ternary keys and the ternary route slots. A write becomes visible to the first lookup issued after the write cycle.

Top module: `hybrid_index_table`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `res_valid` is 0 and every entry in all three stores is invalid, so no lookup returns a result until entries are written.
- R2: The direct table is indexed by `lk_addr[31:20]` (the top `IDX_BITS` = 12 bits). A valid direct entry supplies pipe, stage and node when the ternary path is not usable.
- R3: A ternary entry matches when it is valid and `((lk_addr ^ key) & mask) == 0`.
- R4: Among matching ternary entries, the one with the largest stored length wins. On equal lengths, the lowest entry index wins.
- R5: When the winning ternary entry's route slot is valid, its pipe, stage and node are output, even if the direct entry is also valid.
- R6: The winning ternary entry selects the route slot with the same index. If that slot is invalid, the direct result is used.
- R7: If neither path gives a valid route, `res_valid` is 0 and `res_pipe`, `res_stage` and `res_node` are 0.
- R8: The result of a request made with `lk_valid` high at clock edge N appears on the outputs after edge N. A cycle with `lk_valid` low yields `res_valid` 0 after the next edge.
- R9: A write takes effect from the lookup issued in the cycle after it. A lookup in the same cycle as a write sees the old contents.
- R10: Write targets are selected by `wr_sel`: 0 selects the direct table, 1 the ternary key, 2 the ternary route slot, and 3 writes nothing. `wr_ok` = 0 invalidates the addressed entry. A ternary or route-slot write with `wr_idx` >= `TERN_DEPTH` writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Destination address to look up |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 direct, 1 ternary key, 2 ternary route slot, 3 none |
| wr_idx | input | 12 | Entry index for the write |
| wr_key | input | 32 | Ternary key value |
| wr_mask | input | 32 | Ternary care mask (1 = compare bit) |
| wr_len | input | 6 | Ternary prefix length used for priority |
| wr_ok | input | 1 | Valid bit written with the entry |
| wr_pipe | input | 2 | Pipeline ID to store |
| wr_stage | input | 5 | Root stage ID to store |
| wr_node | input | 14 | Root node address to store |
| res_valid | output | 1 | Result valid |
| res_pipe | output | 2 | Selected pipeline ID |
| res_stage | output | 5 | Stage holding the subtrie root |
| res_node | output | 14 | Root node address within that stage |

## Verification
Every lookup result is due exactly one clock edge after its request. The bench drives inputs on the falling edge and samples the four result ports on the following falling edge, after the single capturing rising edge. A write is likewise due one edge after it is driven. Same-cycle write-and-lookup checks therefore compute the expected value from the bench model before the model is updated, and the next lookup is checked against the updated model.

// File: rtl/ixt_pkg.sv
// Shared widths and the route record used by every part of the index table.
// Assumes a 32-bit address space and at most 32 stages per pipeline.
package ixt_pkg;
    localparam int ADDR_W  = 32;
    localparam int PIPE_W  = 2;
    localparam int STAGE_W = 5;
    localparam int NODE_W  = 14;
    localparam int LEN_W   = 6;

    // Where a subtrie root lives: pipeline, stage within it, node address.
    typedef struct packed {
        logic [PIPE_W-1:0]  pipe;
        logic [STAGE_W-1:0] stage;
        logic [NODE_W-1:0]  node;
    } route_t;

    // Write target codes carried on wr_sel.
    typedef enum logic [1:0] {
        WSEL_DIRECT = 2'd0,
        WSEL_TKEY   = 2'd1,
        WSEL_TROUTE = 2'd2,
        WSEL_NONE   = 2'd3
    } wsel_e;
endpackage

// File: rtl/ixt_route_table.sv
// Route table: DEPTH route records with a valid bit each, one write port and
// one combinational read port. Only the valid bits are reset; the data
// words are don't-care until written. Assumes DEPTH is a power of two.
module ixt_route_table
    import ixt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wvalid,
    input  route_t        wdata,
    input  logic [AW-1:0] raddr,
    output logic          rvalid,
    output route_t        rdata
);
    route_t           mem [DEPTH];
    logic [DEPTH-1:0] vld;

    // Valid bits: cleared by reset, set or cleared by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (we) begin
            vld[waddr] <= wvalid;
        end
    end

    // Data words: stored on every write, never reset.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: returns the current contents of the addressed entry.
    always_comb begin
        rvalid = vld[raddr];
        rdata  = mem[raddr];
    end
endmodule

// File: rtl/ixt_tern_match.sv
// Register-based ternary match array. Each entry holds key, care mask,
// priority length and valid bit. All entries are compared in parallel; the
// winner is the matching entry with the largest length, ties going to the
// lowest index. Length is not derived from the mask; software keeps them
// consistent.
module ixt_tern_match
    import ixt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     widx,
    input  logic [ADDR_W-1:0] wkey,
    input  logic [ADDR_W-1:0] wmask,
    input  logic [LEN_W-1:0]  wlen,
    input  logic              wvalid,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [AW-1:0]     win
);
    logic [DEPTH-1:0] match;
    logic [LEN_W-1:0] len_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic              vld_q;
        logic [ADDR_W-1:0] key_q;
        logic [ADDR_W-1:0] mask_q;
        logic              sel;

        assign sel = we && (widx == AW'(g));

        // Entry valid bit: reset to empty, updated by writes to this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
            end else if (sel) begin
                vld_q <= wvalid;
            end
        end

        // Entry key, mask and length: loaded by writes to this entry.
        always_ff @(posedge clk) begin
            if (sel) begin
                key_q    <= wkey;
                mask_q   <= wmask;
                len_q[g] <= wlen;
            end
        end

        assign match[g] = vld_q && (((addr ^ key_q) & mask_q) == '0);
    end

    // Winner select: longest length, ties kept by the lower index.
    always_comb begin
        logic [LEN_W-1:0] best;
        hit  = 1'b0;
        win  = '0;
        best = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i] && (!hit || len_q[i] > best)) begin
                hit  = 1'b1;
                win  = AW'(i);
                best = len_q[i];
            end
        end
    end
endmodule

// File: rtl/hybrid_index_table.sv
// Subtrie index table. Looks up an address in a direct table (top IDX_BITS
// bits) and in a ternary array whose winner selects a route slot. A usable
// ternary result overrides the direct one. The result is registered, so it
// appears one edge after the request. Writes land at the same edge, so a
// same-cycle lookup sees the old contents.
module hybrid_index_table
    import ixt_pkg::*;
#(
    parameter int IDX_BITS   = 12,
    parameter int TERN_DEPTH = 16,
    localparam int TAW = $clog2(TERN_DEPTH),
    localparam int WI  = (IDX_BITS > TAW) ? IDX_BITS : TAW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [WI-1:0]      wr_idx,
    input  logic [ADDR_W-1:0]  wr_key,
    input  logic [ADDR_W-1:0]  wr_mask,
    input  logic [LEN_W-1:0]   wr_len,
    input  logic               wr_ok,
    input  logic [PIPE_W-1:0]  wr_pipe,
    input  logic [STAGE_W-1:0] wr_stage,
    input  logic [NODE_W-1:0]  wr_node,
    output logic               res_valid,
    output logic [PIPE_W-1:0]  res_pipe,
    output logic [STAGE_W-1:0] res_stage,
    output logic [NODE_W-1:0]  res_node
);
    route_t             wr_route;
    logic               t_in_range;
    logic               we_dir, we_tkey, we_troute;
    logic [IDX_BITS-1:0] d_idx;
    logic               d_valid;
    route_t             d_info;
    logic               t_hit;
    logic [TAW-1:0]     t_win;
    logic               s_valid;
    route_t             s_info;
    logic               t_use;
    route_t             res_q;

    // Write decode: target select and ternary index range check.
    always_comb begin
        wr_route   = '{pipe: wr_pipe, stage: wr_stage, node: wr_node};
        t_in_range = (wr_idx < WI'(TERN_DEPTH));
        we_dir     = wr_en && (wsel_e'(wr_sel) == WSEL_DIRECT);
        we_tkey    = wr_en && (wsel_e'(wr_sel) == WSEL_TKEY)   && t_in_range;
        we_troute  = wr_en && (wsel_e'(wr_sel) == WSEL_TROUTE) && t_in_range;
    end

    assign d_idx = lk_addr[ADDR_W-1 -: IDX_BITS];

    ixt_route_table #(.DEPTH(1 << IDX_BITS)) u_direct (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we_dir),
        .waddr  (wr_idx[IDX_BITS-1:0]),
        .wvalid (wr_ok),
        .wdata  (wr_route),
        .raddr  (d_idx),
        .rvalid (d_valid),
        .rdata  (d_info)
    );

    ixt_tern_match #(.DEPTH(TERN_DEPTH)) u_tern (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we_tkey),
        .widx   (wr_idx[TAW-1:0]),
        .wkey   (wr_key),
        .wmask  (wr_mask),
        .wlen   (wr_len),
        .wvalid (wr_ok),
        .addr   (lk_addr),
        .hit    (t_hit),
        .win    (t_win)
    );

    ixt_route_table #(.DEPTH(TERN_DEPTH)) u_troute (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we_troute),
        .waddr  (wr_idx[TAW-1:0]),
        .wvalid (wr_ok),
        .wdata  (wr_route),
        .raddr  (t_win),
        .rvalid (s_valid),
        .rdata  (s_info)
    );

    assign t_use = t_hit && s_valid;

    // Result register: ternary route first, then direct, else empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_q     <= '0;
        end else if (lk_valid && t_use) begin
            res_valid <= 1'b1;
            res_q     <= s_info;
        end else if (lk_valid && d_valid) begin
            res_valid <= 1'b1;
            res_q     <= d_info;
        end else begin
            res_valid <= 1'b0;
            res_q     <= '0;
        end
    end

    assign res_pipe  = res_q.pipe;
    assign res_stage = res_q.stage;
    assign res_node  = res_q.node;
endmodule

// File: rtl/ixt_checker.sv
// Timing and selection properties of the index table, bound to the top.
// Relates the two lookup paths' combinational outputs to the registered
// result one edge later.
module ixt_checker
    import ixt_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   lk_valid,
    input logic   t_use,
    input route_t s_info,
    input logic   d_valid,
    input route_t d_info,
    input logic   res_valid,
    input route_t res_q
);
    // R1: a reset edge leaves no valid result.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    // R8: no request, no result one edge later.
    assert_idle_gives_nothing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R5: a usable ternary route wins over the direct table.
    assert_tern_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && t_use) |=> (res_valid && res_q == $past(s_info)));

    // R2: without a usable ternary route the direct entry is passed on.
    assert_direct_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !t_use && d_valid) |=> (res_valid && res_q == $past(d_info)));

    // R7: with neither path valid the result is empty and zero.
    assert_empty_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !t_use && !d_valid) |=> (!res_valid && res_q == '0));
endmodule

bind hybrid_index_table ixt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .t_use     (t_use),
    .s_info    (s_info),
    .d_valid   (d_valid),
    .d_info    (d_info),
    .res_valid (res_valid),
    .res_q     (res_q)
);

// File: tb/hybrid_index_table_test.sv
module hybrid_index_table_test;
    import ixt_pkg::*;

    localparam int TD = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               lk_valid = 1'b0;
    logic [31:0]        lk_addr = '0;
    logic               wr_en = 1'b0;
    logic [1:0]         wr_sel = '0;
    logic [11:0]        wr_idx = '0;
    logic [31:0]        wr_key = '0;
    logic [31:0]        wr_mask = '0;
    logic [5:0]         wr_len = '0;
    logic               wr_ok = 1'b0;
    logic [1:0]         wr_pipe = '0;
    logic [4:0]         wr_stage = '0;
    logic [13:0]        wr_node = '0;
    logic               res_valid;
    logic [1:0]         res_pipe;
    logic [4:0]         res_stage;
    logic [13:0]        res_node;

    int total = 0;
    int bad = 0;

    // Bench model of the three stores.
    bit     dv [4096];
    route_t dinfo [4096];
    bit          tv [TD];
    logic [31:0] tk [TD];
    logic [31:0] tm [TD];
    logic [5:0]  tl [TD];
    bit     sv [TD];
    route_t sinfo [TD];

    hybrid_index_table uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_key(wr_key),
        .wr_mask(wr_mask), .wr_len(wr_len), .wr_ok(wr_ok), .wr_pipe(wr_pipe),
        .wr_stage(wr_stage), .wr_node(wr_node), .res_valid(res_valid),
        .res_pipe(res_pipe), .res_stage(res_stage), .res_node(res_node)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [31:0] pmask(input int len);
        return (len == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - len));
    endfunction

    // Expected lookup result from the requirements (R2-R7).
    function automatic void expect_of(input logic [31:0] a, output bit v, output route_t r);
        int best = -1;
        logic [5:0] bl = '0;
        for (int i = 0; i < TD; i++) begin
            if (tv[i] && ((a ^ tk[i]) & tm[i]) == 32'h0 && (best < 0 || tl[i] > bl)) begin
                best = i;
                bl = tl[i];
            end
        end
        if (best >= 0 && sv[best]) begin
            v = 1'b1; r = sinfo[best];
        end else if (dv[a[31:20]]) begin
            v = 1'b1; r = dinfo[a[31:20]];
        end else begin
            v = 1'b0; r = '0;
        end
    endfunction

    // Apply a write to the model as R10 defines it.
    function automatic void model_write(input logic [1:0] s, input logic [11:0] idx,
                                        input logic [31:0] k, input logic [31:0] m,
                                        input logic [5:0] l, input bit ok, input route_t r);
        if (s == 2'd0) begin
            dv[idx] = ok; dinfo[idx] = r;
        end else if (s == 2'd1 && idx < TD) begin
            tv[idx] = ok; tk[idx] = k; tm[idx] = m; tl[idx] = l;
        end else if (s == 2'd2 && idx < TD) begin
            sv[idx] = ok; sinfo[idx] = r;
        end
    endfunction

    task automatic check(input string req, input bit ev, input route_t er);
        route_t got;
        got = '{pipe: res_pipe, stage: res_stage, node: res_node};
        total++;
        if (res_valid !== ev || got !== er) begin
            bad++;
            $display("FAIL %s: got valid=%0b route=%h expected valid=%0b route=%h",
                     req, res_valid, got, ev, er);
        end
    endtask

    task automatic set_write(input logic [1:0] s, input logic [11:0] idx,
                             input logic [31:0] k, input logic [31:0] m,
                             input logic [5:0] l, input bit ok, input route_t r);
        wr_en = 1'b1; wr_sel = s; wr_idx = idx; wr_key = k; wr_mask = m;
        wr_len = l; wr_ok = ok; wr_pipe = r.pipe; wr_stage = r.stage; wr_node = r.node;
    endtask

    // One write cycle; starts and ends on a falling edge.
    task automatic do_write(input logic [1:0] s, input logic [11:0] idx,
                            input logic [31:0] k, input logic [31:0] m,
                            input logic [5:0] l, input bit ok, input route_t r);
        set_write(s, idx, k, m, l, ok, r);
        @(negedge clk);
        wr_en = 1'b0;
        model_write(s, idx, k, m, l, ok, r);
    endtask

    // One lookup; result sampled one edge later (R8).
    task automatic do_look(input logic [31:0] a, input string req);
        bit ev;
        route_t er;
        lk_valid = 1'b1; lk_addr = a;
        expect_of(a, ev, er);
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, ev, er);
    endtask

    function automatic route_t rt(input int p, input int s, input int n);
        return '{pipe: 2'(p), stage: 5'(s), node: 14'(n)};
    endfunction

    initial begin
        bit ev;
        route_t er;
        for (int i = 0; i < 4096; i++) begin dv[i] = 0; dinfo[i] = '0; end
        for (int i = 0; i < TD; i++) begin
            tv[i] = 0; tk[i] = '0; tm[i] = '0; tl[i] = '0; sv[i] = 0; sinfo[i] = '0;
        end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: after reset nothing is valid.
        check("R1 reset output", 1'b0, '0);
        do_look(32'h1234_5678, "R1 empty after reset");

        // R2: direct entry indexed by addr[31:20].
        do_write(2'd0, 12'h123, '0, '0, '0, 1'b1, rt(1, 7, 300));
        do_look(32'h1230_0000, "R2 direct hit");
        do_look(32'h123F_FFFF, "R2 direct hit other low bits");
        do_look(32'h1240_0000, "R2 neighbour index empty");

        // R3 and R5: ternary /16 over same region, route slot 3.
        do_write(2'd1, 12'd3, 32'h1234_0000, pmask(16), 6'd16, 1'b1, '0);
        do_look(32'h1234_5678, "R6 ternary hit without route slot falls back");
        do_write(2'd2, 12'd3, '0, '0, '0, 1'b1, rt(2, 9, 1000));
        do_look(32'h1234_5678, "R5 ternary overrides direct");
        do_look(32'h1235_0000, "R3 mask mismatch uses direct");

        // R4: longer prefix wins; equal length keeps lower index.
        do_write(2'd1, 12'd9, 32'h1234_5600, pmask(24), 6'd24, 1'b1, '0);
        do_write(2'd2, 12'd9, '0, '0, '0, 1'b1, rt(3, 4, 77));
        do_look(32'h1234_56AB, "R4 longest length wins");
        do_write(2'd1, 12'd5, 32'h1234_5600, pmask(24), 6'd24, 1'b1, '0);
        do_write(2'd2, 12'd5, '0, '0, '0, 1'b1, rt(0, 31, 5555));
        do_look(32'h1234_56AB, "R4 tie goes to lower index");

        // R7: no path valid.
        do_look(32'hFFFF_0000, "R7 no entry gives zero result");

        // R8: idle cycle.
        lk_addr = 32'h1234_56AB;
        @(negedge clk);
        check("R8 idle cycle", 1'b0, '0);

        // R9: same-cycle write sees old content, next lookup sees new.
        set_write(2'd2, 12'd5, '0, '0, '0, 1'b1, rt(1, 1, 1));
        lk_valid = 1'b1; lk_addr = 32'h1234_56AB;
        expect_of(lk_addr, ev, er);
        @(negedge clk);
        lk_valid = 1'b0; wr_en = 1'b0;
        check("R9 same-cycle lookup sees old", ev, er);
        model_write(2'd2, 12'd5, '0, '0, '0, 1'b1, rt(1, 1, 1));
        do_look(32'h1234_56AB, "R9 next lookup sees new");

        // R10: sel 3 and out-of-range writes do nothing; wr_ok 0 invalidates.
        do_write(2'd3, 12'd5, '0, '0, '0, 1'b1, rt(2, 2, 2));
        do_look(32'h1234_56AB, "R10 sel 3 writes nothing");
        do_write(2'd1, 12'd200, 32'hFFFF_0000, pmask(16), 6'd16, 1'b1, '0);
        do_write(2'd2, 12'd200, '0, '0, '0, 1'b1, rt(3, 3, 3));
        do_look(32'hFFFF_0000, "R10 out-of-range ternary write ignored");
        do_write(2'd1, 12'd5, '0, '0, '0, 1'b0, '0);
        do_look(32'h1234_56AB, "R10 invalidated key drops out");
        do_write(2'd0, 12'h123, '0, '0, '0, 1'b0, '0);
        do_look(32'h1235_0000, "R10 invalidated direct entry");

        // Random mix of writes and lookups over a small address region.
        for (int it = 0; it < 1500; it++) begin
            int op = $urandom % 4;
            if (op == 0) begin
                int len = 8 + ($urandom % 24);
                logic [31:0] k = {4'($urandom % 16), 8'h00, 20'($urandom)} & pmask(len);
                do_write(2'd1, 12'($urandom % 20), k, pmask(len), 6'(len),
                         ($urandom % 5) != 0, '0);
            end else if (op == 1) begin
                do_write(2'($urandom % 4), 12'($urandom % 20), '0, '0, '0,
                         ($urandom % 5) != 0, rt($urandom, $urandom, $urandom));
            end else begin
                logic [31:0] a;
                int j = $urandom % TD;
                if ($urandom % 2) a = (tk[j] & tm[j]) | ($urandom & ~tm[j]);
                else a = {12'($urandom % 20), 20'($urandom)};
                do_look(a, "R3 R4 R5 R6 random lookup");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule